// File: doc/BRIEF.md
# Serial Controller Status Register

This block keeps the eight status flags of a programmable serial controller and drives three active-low ready/attention pins from them. Neighbouring logic supplies single-cycle event strobes: the transmitter reports a CPU write into its holding register, the move of that character into the shift register and the end of each shifted character. The receiver reports each character it places in its holding register, together with parity and framing flags for that character. The CPU interface reports reads of the receive holding register and of the status register, and issues an error-reset command.

The block also samples the two modem-status pins (carrier detect and data-set ready, both active low). Each passes through a two-stage synchronizer. A change on either one raises an attention flag while the transmitter or the receiver is enabled. Each bit has its own set and clear rule, all evaluated at one clock edge. Event effects show on `status` one cycle after the strobe. The loopback mode input can hide the ready indications from the CPU.

Top module: `ser_status`

## Requirements
- R1: Bit 0 (transmit ready) is 1 while the transmitter is enabled and the transmit holding register is empty. A holding-register load (`thrLoad`) clears it from the next cycle. A transfer to the shift register (`thrXfer`) sets it again.
- R2: Bit 0 stays 0 while `txEnable` is 0 or `loopMode` is 2'b01 (echo) or 2'b11 (remote loopback). Enabling the transmitter while a loaded character still waits in the holding register leaves bit 0 at 0.
- R3: Bit 1 (receive ready) is set one cycle after `rxCharDone` while `rxEnable` is 1. It is cleared by `rhrRead` or by `rxEnable` at 0, and `rxCharDone` is ignored while the receiver is disabled.
- R4: Bit 4 (overrun) is set when `rxCharDone` arrives while bit 1 is already 1 and no `rhrRead` comes in the same cycle. A later `rhrRead` does not clear it.
- R5: The empty part of bit 2 is set by `txDone` when the holding register is empty and not being loaded in that cycle. It is cleared only by `thrLoad`, so it is not affected by a status read. It is never set before the first `txDone`.
- R6: The modem-change part of bit 2 is set when the synchronized DCD or DSR level changes while `txEnable` or `rxEnable` is 1. It is cleared by `statusRead`, and a change in the same cycle as the read wins. With both enables at 0, a change is ignored.
- R7: Bit 3 (parity error) is set by `rxCharDone` with `rxParityErr` only when `asyncMode` and `parityEnable` are both 1.
- R8: Bit 5 (framing error, first stop bit missing) is set by `rxCharDone` with `rxFrameErr` only when `asyncMode` is 1.
- R9: Bits 3, 4 and 5 are cleared by the `errReset` command or by `rxEnable` at 0. A clear wins over a set in the same cycle.
- R10: Bit 6 is the inverse of `dcdN` and bit 7 is the inverse of `dsrN`, each visible after two clock edges of synchronization.
- R11: `txRdyN`, `rxRdyN` and `txEmtN` are low exactly when bits 0, 1 and 2 are 1. All three are held high while `loopMode` is 2'b01 or 2'b11.
- R12: After reset, bits 0 to 5 are 0 and all three pins are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txEnable | input | 1 | Transmitter enable |
| rxEnable | input | 1 | Receiver enable |
| loopMode | input | 2 | 00 normal, 01 echo, 10 local loop, 11 remote loop |
| asyncMode | input | 1 | 1 for asynchronous character framing |
| parityEnable | input | 1 | Parity checking on |
| thrLoad | input | 1 | CPU wrote the transmit holding register |
| thrXfer | input | 1 | Holding register moved into the shift register |
| txDone | input | 1 | Transmit shift register finished a character |
| rxCharDone | input | 1 | Character placed in the receive holding register |
| rxParityErr | input | 1 | Parity error on that character |
| rxFrameErr | input | 1 | Missing first stop bit on that character |
| rhrRead | input | 1 | CPU read of the receive holding register |
| statusRead | input | 1 | CPU read of the status register |
| errReset | input | 1 | Error-reset command |
| dcdN | input | 1 | Carrier detect pin, active low, asynchronous |
| dsrN | input | 1 | Data-set ready pin, active low, asynchronous |
| status | output | 8 | Status flags, bit 0 to bit 7 |
| txRdyN | output | 1 | Transmit ready pin, active low |
| rxRdyN | output | 1 | Receive ready pin, active low |
| txEmtN | output | 1 | Empty / modem change pin, active low |

## Verification
The transmit tests load and transfer characters in different orders. This tells the ready bit apart from the empty flag. It also checks that the empty flag cannot be set by a shift completion while a character is waiting. Receive tests place one character, then two without a read, with and without the error flags, under each mode setting. These show which qualifier gates which bit and which event clears it. The modem tests move each pin with the enables on and off, and sample each cycle around the synchronizer delay. This separates the level bits from the change flag and shows that a status read clears only the change part of bit 2.

// File: rtl/ser_status_pkg.sv
package ser_status_pkg;
  localparam int STATUS_W  = 8;
  localparam int MODEM_W   = 2;   // index 0 carrier detect, index 1 data-set ready

  localparam int B_TXRDY   = 0;
  localparam int B_RXRDY   = 1;
  localparam int B_ATTN    = 2;
  localparam int B_PARITY  = 3;
  localparam int B_OVERRUN = 4;
  localparam int B_FRAME   = 5;
  localparam int B_DCD     = 6;
  localparam int B_DSR     = 7;

  typedef enum logic [1:0] {
    LOOP_NONE   = 2'b00,
    LOOP_ECHO   = 2'b01,
    LOOP_LOCAL  = 2'b10,
    LOOP_REMOTE = 2'b11
  } loopMode_e;

  // strobes handed from control to datapath, valid for one cycle
  typedef struct packed {
    logic txAllow;   // transmit ready may be shown
    logic holdLoad;
    logic holdXfer;
    logic txDone;
    logic rxAccept;  // character accepted by an enabled receiver
    logic rxFlush;   // receiver disabled
    logic rhrRead;
    logic parSet;
    logic frmSet;
    logic errClr;
    logic chgSet;
    logic chgClr;
    logic pinMask;   // hold the ready pins inactive
  } statStrobe_t;
endpackage

// File: rtl/ser_status_ctrl.sv
module ser_status_ctrl
  import ser_status_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               txEnable,
  input  logic               rxEnable,
  input  logic [1:0]         loopMode,
  input  logic               asyncMode,
  input  logic               parityEnable,
  input  logic               thrLoad,
  input  logic               thrXfer,
  input  logic               txDone,
  input  logic               rxCharDone,
  input  logic               rxParityErr,
  input  logic               rxFrameErr,
  input  logic               rhrRead,
  input  logic               statusRead,
  input  logic               errReset,
  input  logic [MODEM_W-1:0] modemPinN,
  output statStrobe_t        strb,
  output logic [MODEM_W-1:0] modemActive
);
  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [MODEM_W-1:0] syncQ [SYNC_STAGES];
  logic [MODEM_W-1:0] prevLvl;
  logic [MODEM_W-1:0] modemLvl;
  logic               echoLike;
  logic               rxAccept;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncQ[i] <= '1;
      prevLvl <= '1;
    end else begin
      syncQ[0] <= modemPinN;
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
      prevLvl <= modemLvl;
    end
  end

  assign modemLvl    = syncQ[LAST_STAGE];
  assign modemActive = ~modemLvl;

  assign echoLike = (loopMode_e'(loopMode) == LOOP_ECHO) ||
                    (loopMode_e'(loopMode) == LOOP_REMOTE);
  assign rxAccept = rxCharDone & rxEnable;

  always_comb begin
    strb          = '0;
    strb.txAllow  = txEnable & ~echoLike;
    strb.holdLoad = thrLoad;
    strb.holdXfer = thrXfer;
    strb.txDone   = txDone;
    strb.rxAccept = rxAccept;
    strb.rxFlush  = ~rxEnable;
    strb.rhrRead  = rhrRead;
    strb.parSet   = rxAccept & asyncMode & parityEnable & rxParityErr;
    strb.frmSet   = rxAccept & asyncMode & rxFrameErr;
    strb.errClr   = errReset | ~rxEnable;
    strb.chgSet   = (|(modemLvl ^ prevLvl)) & (txEnable | rxEnable);
    strb.chgClr   = statusRead;
    strb.pinMask  = echoLike;
  end

  // a change strobe needs the synchronized level to have moved since last cycle
  AST_CHG_NEEDS_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    strb.chgSet |=> (prevLvl != $past(prevLvl))) else $error("change without move"); // R6
endmodule

// File: rtl/ser_status_dp.sv
module ser_status_dp
  import ser_status_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  statStrobe_t         strb,
  input  logic [MODEM_W-1:0]  modemActive,
  output logic [STATUS_W-1:0] status,
  output logic                txRdyN,
  output logic                rxRdyN,
  output logic                txEmtN
);
  logic holdFull, holdNext;
  logic txRdyQ, rxRdyQ, emptyQ, chgQ, parQ, ovrQ, frmQ;

  assign holdNext = strb.holdLoad | (holdFull & ~strb.holdXfer);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdFull <= 1'b0;
      txRdyQ   <= 1'b0;
      rxRdyQ   <= 1'b0;
      emptyQ   <= 1'b0;
      chgQ     <= 1'b0;
      parQ     <= 1'b0;
      ovrQ     <= 1'b0;
      frmQ     <= 1'b0;
    end else begin
      holdFull <= holdNext;
      txRdyQ   <= strb.txAllow & ~holdNext;

      if (strb.rxFlush)       rxRdyQ <= 1'b0;
      else if (strb.rxAccept) rxRdyQ <= 1'b1;
      else if (strb.rhrRead)  rxRdyQ <= 1'b0;

      if (strb.holdLoad)                     emptyQ <= 1'b0;
      else if (strb.txDone && !holdFull)     emptyQ <= 1'b1;

      if (strb.chgSet)      chgQ <= 1'b1;
      else if (strb.chgClr) chgQ <= 1'b0;

      if (strb.errClr) begin
        parQ <= 1'b0;
        ovrQ <= 1'b0;
        frmQ <= 1'b0;
      end else begin
        if (strb.parSet) parQ <= 1'b1;
        if (strb.frmSet) frmQ <= 1'b1;
        if (strb.rxAccept && rxRdyQ && !strb.rhrRead) ovrQ <= 1'b1;
      end
    end
  end

  always_comb begin
    status            = '0;
    status[B_TXRDY]   = txRdyQ;
    status[B_RXRDY]   = rxRdyQ;
    status[B_ATTN]    = emptyQ | chgQ;
    status[B_PARITY]  = parQ;
    status[B_OVERRUN] = ovrQ;
    status[B_FRAME]   = frmQ;
    status[B_DCD]     = modemActive[0];
    status[B_DSR]     = modemActive[1];
  end

  assign txRdyN = ~txRdyQ | strb.pinMask;
  assign rxRdyN = ~rxRdyQ | strb.pinMask;
  assign txEmtN = ~(emptyQ | chgQ) | strb.pinMask;

  AST_TXRDY_NOT_WHEN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    holdFull |-> !status[B_TXRDY]) else $error("ready with full holding"); // R1
  AST_TXRDY_SUPPRESSED: assert property (@(posedge clk) disable iff (!rstN)
    !strb.txAllow |=> !status[B_TXRDY]) else $error("ready while suppressed"); // R2
  AST_RXRDY_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    strb.rxFlush |=> !status[B_RXRDY]) else $error("rx ready after disable"); // R3
  AST_NO_OVERRUN_WITHOUT_FULL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[B_OVERRUN]) |-> $past(status[B_RXRDY])) else $error("overrun with empty holding"); // R4
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strb.errClr |=> (status[B_FRAME:B_PARITY] == 3'b000)) else $error("errors survive clear"); // R9
endmodule

// File: rtl/ser_status.sv
module ser_status
  import ser_status_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txEnable,
  input  logic       rxEnable,
  input  logic [1:0] loopMode,
  input  logic       asyncMode,
  input  logic       parityEnable,
  input  logic       thrLoad,
  input  logic       thrXfer,
  input  logic       txDone,
  input  logic       rxCharDone,
  input  logic       rxParityErr,
  input  logic       rxFrameErr,
  input  logic       rhrRead,
  input  logic       statusRead,
  input  logic       errReset,
  input  logic       dcdN,
  input  logic       dsrN,
  output logic [7:0] status,
  output logic       txRdyN,
  output logic       rxRdyN,
  output logic       txEmtN
);
  statStrobe_t        strb;
  logic [MODEM_W-1:0] modemActive;

  ser_status_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .rxEnable(rxEnable),
    .loopMode(loopMode), .asyncMode(asyncMode), .parityEnable(parityEnable),
    .thrLoad(thrLoad), .thrXfer(thrXfer), .txDone(txDone),
    .rxCharDone(rxCharDone), .rxParityErr(rxParityErr), .rxFrameErr(rxFrameErr),
    .rhrRead(rhrRead), .statusRead(statusRead), .errReset(errReset),
    .modemPinN({dsrN, dcdN}), .strb(strb), .modemActive(modemActive)
  );

  ser_status_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .modemActive(modemActive),
    .status(status), .txRdyN(txRdyN), .rxRdyN(rxRdyN), .txEmtN(txEmtN)
  );
endmodule

// File: tb/ser_status_bench.sv
module ser_status_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txEnable = 0, rxEnable = 0, asyncMode = 1, parityEnable = 0;
  logic [1:0] loopMode = 2'b00;
  logic thrLoad = 0, thrXfer = 0, txDone = 0, rxCharDone = 0;
  logic rxParityErr = 0, rxFrameErr = 0, rhrRead = 0, statusRead = 0, errReset = 0;
  logic dcdN = 1, dsrN = 1;
  logic [7:0] status;
  logic txRdyN, rxRdyN, txEmtN;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  ser_status u_ser_status (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .rxEnable(rxEnable),
    .loopMode(loopMode), .asyncMode(asyncMode), .parityEnable(parityEnable),
    .thrLoad(thrLoad), .thrXfer(thrXfer), .txDone(txDone),
    .rxCharDone(rxCharDone), .rxParityErr(rxParityErr), .rxFrameErr(rxFrameErr),
    .rhrRead(rhrRead), .statusRead(statusRead), .errReset(errReset),
    .dcdN(dcdN), .dsrN(dsrN), .status(status),
    .txRdyN(txRdyN), .rxRdyN(rxRdyN), .txEmtN(txEmtN)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic test_reset();
    tick();
    chk("R12 status", status, 8'h00);
    chk("R12 pins", {5'b0, txRdyN, rxRdyN, txEmtN}, 8'h07);
  endtask

  task automatic test_tx_ready();
    txEnable = 1; tick();
    chk("R1 ready after enable", status[0], 1);
    chk("R11 txRdyN low", txRdyN, 0);
    thrLoad = 1; tick(); thrLoad = 0;
    chk("R1 cleared by load", status[0], 0);
    thrXfer = 1; tick(); thrXfer = 0;
    chk("R1 set by transfer", status[0], 1);
  endtask

  task automatic test_tx_suppress();
    loopMode = 2'b01; tick();
    chk("R2 echo hides ready", status[0], 0);
    chk("R11 echo pin high", txRdyN, 1);
    loopMode = 2'b11; tick();
    chk("R2 remote hides ready", status[0], 0);
    loopMode = 2'b00; txEnable = 0; tick();
    chk("R2 disabled", status[0], 0);
    thrLoad = 1; tick(); thrLoad = 0;
    txEnable = 1; tick();
    chk("R2 waiting char keeps 0", status[0], 0);
    thrXfer = 1; tick(); thrXfer = 0;
    chk("R2 after transfer", status[0], 1);
  endtask

  task automatic test_empty();
    chk("R5 not set before first done", status[2], 0);
    txDone = 1; tick(); txDone = 0;
    chk("R5 empty set", status[2], 1);
    chk("R11 txEmtN low", txEmtN, 0);
    statusRead = 1; tick(); statusRead = 0;
    chk("R5 status read keeps empty", status[2], 1);
    thrLoad = 1; tick(); thrLoad = 0;
    chk("R5 load clears", status[2], 0);
    txDone = 1; tick(); txDone = 0;
    chk("R5 char waiting blocks empty", status[2], 0);
    thrXfer = 1; tick(); thrXfer = 0;
    chk("R5 still clear", status[2], 0);
  endtask

  task automatic test_rx();
    rxEnable = 1; tick();
    rxCharDone = 1; tick(); rxCharDone = 0;
    chk("R3 rx ready set", status[1], 1);
    chk("R11 rxRdyN low", rxRdyN, 0);
    rhrRead = 1; tick(); rhrRead = 0;
    chk("R3 read clears", status[1], 0);
    rxCharDone = 1; tick(); tick(); rxCharDone = 0;
    chk("R4 overrun set", status[4], 1);
    rhrRead = 1; tick(); rhrRead = 0;
    chk("R4 read keeps overrun", {status[4], status[1]}, 8'h02);
    errReset = 1; tick(); errReset = 0;
    chk("R9 reset command clears overrun", status[4], 0);
    rxEnable = 0; rxCharDone = 1; tick(); rxCharDone = 0;
    chk("R3 ignored while disabled", status[1], 0);
    rxEnable = 1; tick();
  endtask

  task automatic test_errors();
    parityEnable = 0; rxParityErr = 1; rxCharDone = 1; tick();
    rxCharDone = 0; rxParityErr = 0;
    chk("R7 parity off ignored", status[3], 0);
    parityEnable = 1; rxParityErr = 1; rxCharDone = 1; tick();
    rxCharDone = 0; rxParityErr = 0;
    chk("R7 parity error", status[3], 1);
    rxFrameErr = 1; rxCharDone = 1; tick(); rxCharDone = 0; rxFrameErr = 0;
    chk("R8 framing error", status[5], 1);
    errReset = 1; rxFrameErr = 1; rxCharDone = 1; tick();
    errReset = 0; rxFrameErr = 0; rxCharDone = 0;
    chk("R9 clear wins", status[5:3], 3'b000);
    asyncMode = 0; rxFrameErr = 1; rxParityErr = 1; rxCharDone = 1; tick();
    rxFrameErr = 0; rxParityErr = 0; rxCharDone = 0;
    chk("R8 R7 sync mode ignores", status[5:3], 3'b010);
    asyncMode = 1; rxParityErr = 1; rxCharDone = 1; tick();
    rxParityErr = 0; rxCharDone = 0;
    rxEnable = 0; tick();
    chk("R9 disable clears errors and R3 ready", status[5:1], 5'b00000);
    parityEnable = 0;
  endtask

  task automatic test_modem();
    dcdN = 0; tick();
    chk("R10 one edge not yet", status[6], 0);
    tick();
    chk("R10 dcd seen", status[6], 1);
    chk("R6 change not yet", status[2], 0);
    tick();
    chk("R6 change flag", status[2], 1);
    statusRead = 1; tick(); statusRead = 0;
    chk("R6 read clears change", status[2], 0);
    dsrN = 0; tick(); tick();
    statusRead = 1; tick(); statusRead = 0;
    chk("R6 change wins over read", {status[7], status[2]}, 8'h03);
    statusRead = 1; tick(); statusRead = 0;
    txEnable = 0; rxEnable = 0; dsrN = 1; tick(); tick(); tick(); tick();
    chk("R6 disabled ignores change", {status[7], status[2]}, 8'h00);
  endtask

  task automatic test_pin_mask();
    rxEnable = 1; rxCharDone = 1; tick(); rxCharDone = 0;
    loopMode = 2'b11; tick();
    chk("R11 remote pins high", {5'b0, txRdyN, rxRdyN, txEmtN}, 8'h07);
    chk("R11 status kept", status[1], 1);
    loopMode = 2'b10; tick();
    chk("R11 local loop pin low", rxRdyN, 0);
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rstN = 1;
    test_reset();
    test_tx_ready();
    test_tx_suppress();
    test_empty();
    test_rx();
    test_errors();
    txEnable = 1;
    test_modem();
    test_pin_mask();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule